// File: doc/BRIEF.md
# Serialized Interrupt Host Controller

This block is the host end of a single-wire serialized interrupt line. The line is open-drain style and has a pull-up. Each polling cycle has three parts. It opens with a six-state start frame. Seventeen data frames of three states each follow. A stop frame closes the cycle. During the data frames any peripheral may pull the line low in the first state of its slot to signal that its interrupt is active. The host samples each of those states and collects the results into a 17-bit vector. It publishes the vector as a whole, with a one-cycle strobe, once the last slot has been read.

The width of the host's stop pulse tells every peripheral the mode of the next cycle. In continuous mode the host opens a new cycle by itself after a fixed idle gap. In quiet mode the line rests until one of two events occurs. Either local logic asks for a poll, or a peripheral pulls the line low to ask for one. In the second case the host treats that low state as the first state of the start frame and continues the frame from there.

One clock cycle equals one state of the line. Prioritizing the collected interrupts and delivering them to a processor belong to other blocks.

Top module: `serial_irq_host`

## Requirements
- R1: While reset is held and in the first state after it, `line_oe` is 0, `irq_status_o` is 0 and `status_vld_o` is 0. The first cycle after reset runs in continuous mode: its start frame begins after `IDLE_GAP` gap states, with no poll request and no peripheral request.
- R2: A start frame has six states. In state 0 the host does not drive the line. In states 1, 2 and 3 it drives the line low. In state 4 it drives the line high. In state 5 it releases the line.
- R3: Seventeen data frames of three states each follow the start frame. The host keeps `line_oe` at 0 for all 51 of these states. Frame k (k = 1..17) is sampled in its first state. A low sample gives `irq_status_o[k-1]` = 1 and a high sample gives 0. The frames map to signals as follows: bit 0 is IRQ0, bit 1 is IRQ1, bit 2 is SMI, bits 3 to 15 are IRQ3 to IRQ15, and bit 16 is IOCHCK.
- R4: `status_vld_o` is high for exactly one clock, in the state that follows the last data state. All 17 bits of `irq_status_o` change in that same clock. At every other time they hold their value.
- R5: The stop frame begins with exactly `STOP_IDLE` states in which the line is released. The host then drives a low pulse. The pulse lasts 3 states when `cont_mode_i` is 1, which selects continuous mode next, and 2 states when `cont_mode_i` is 0, which selects quiet mode next. `cont_mode_i` is read in the last released state of the stop frame.
- R6: Every state in which the host drives the line high follows one of its own low pulses. It lasts exactly one state, and the host releases the line in the next state.
- R7: In continuous mode, state 0 of the next start frame comes exactly `IDLE_GAP` states after the turnaround state of the stop frame. `poll_i` and a low line during the gap have no effect on this timing.
- R8: In quiet mode the host keeps the line released until a request arrives. When `poll_i` is high in a resting state, the next state is start state 0, with the line released, and the host drives low in the state after that.
- R9: In quiet mode, a low line seen in a resting state counts as start state 0. The host drives the line low from the very next state and completes states 1 to 5.
- R10: When `poll_i` is high and the line is low in the same resting state, the peripheral's request wins. The host drives low in the next state, as in R9, and does not insert a released state 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock, one state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Sampled level of the serialized interrupt line |
| line_o | output | 1 | Level the host drives when enabled |
| line_oe | output | 1 | Host output enable for the line |
| cont_mode_i | input | 1 | Mode to announce for the next cycle: 1 continuous, 0 quiet |
| poll_i | input | 1 | Local request to start a cycle while in quiet mode |
| irq_status_o | output | 17 | Decoded interrupt states, bit k-1 for data frame k |
| status_vld_o | output | 1 | One-cycle strobe marking a new `irq_status_o` |

## Verification
In quiet mode two events can start a cycle: a local poll request and a peripheral pulling the line low. Both can land in the same resting state. The bench provokes this by raising `poll_i` and pulling the line low in one idle state. The outcome counts as correct only if the host drives low in the very next state, with no released start state first. The same state offset separates a poll-only start from a peripheral-only start. In continuous gaps the bench injects both events to show they change nothing. Status vectors, stop-pulse widths and gap lengths are compared against values the bench computes from the random slot patterns and mode choices.

// File: rtl/serial_irq_host.sv
module serial_irq_host #(
  parameter int IDLE_GAP  = 4,
  parameter int STOP_IDLE = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_i,
  output logic        line_o,
  output logic        line_oe,
  input  logic        cont_mode_i,
  input  logic        poll_i,
  output logic [16:0] irq_status_o,
  output logic        status_vld_o
);

  localparam int NSLOT = 17;
  localparam int SMAX  = (IDLE_GAP > STOP_IDLE) ? IDLE_GAP : STOP_IDLE;
  localparam int CMAX  = (SMAX > 6) ? SMAX : 6;
  localparam int CW    = $clog2(CMAX + 1);

  typedef enum logic [2:0] {
    PH_IDLE, PH_GAP, PH_START, PH_DATA, PH_SIDLE, PH_SLOW, PH_SREC, PH_STA
  } phase_t;

  phase_t           phase_q;
  logic [CW-1:0]    cnt_q;
  logic [4:0]       slot_q;
  logic [1:0]       sub_q;
  logic             cont_nx_q;
  logic [NSLOT-1:0] shadow_q;
  logic [NSLOT-1:0] status_q;
  logic             vld_q;
  logic             drv_lo;
  logic             drv_hi;

  assign drv_lo = (phase_q == PH_START && cnt_q >= CW'(1) && cnt_q <= CW'(3))
                || phase_q == PH_SLOW;
  assign drv_hi = (phase_q == PH_START && cnt_q == CW'(4)) || phase_q == PH_SREC;

  assign line_oe      = drv_lo | drv_hi;
  assign line_o       = ~drv_lo;
  assign irq_status_o = status_q;
  assign status_vld_o = vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_GAP;
      cnt_q     <= '0;
      slot_q    <= '0;
      sub_q     <= '0;
      cont_nx_q <= 1'b1;
      shadow_q  <= '0;
      status_q  <= '0;
      vld_q     <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (!line_i) begin
            phase_q <= PH_START;
            cnt_q   <= CW'(1);
          end else if (poll_i) begin
            phase_q <= PH_START;
            cnt_q   <= '0;
          end
        end
        PH_GAP: begin
          if (cnt_q == CW'(IDLE_GAP - 1)) begin
            phase_q <= PH_START;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_START: begin
          if (cnt_q == CW'(5)) begin
            phase_q <= PH_DATA;
            slot_q  <= '0;
            sub_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DATA: begin
          if (sub_q == 2'd0) shadow_q[slot_q] <= ~line_i;
          if (sub_q == 2'd2) begin
            sub_q <= '0;
            if (slot_q == 5'(NSLOT - 1)) begin
              phase_q  <= PH_SIDLE;
              cnt_q    <= '0;
              status_q <= shadow_q;
              vld_q    <= 1'b1;
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        PH_SIDLE: begin
          if (cnt_q == CW'(STOP_IDLE - 1)) begin
            phase_q   <= PH_SLOW;
            cnt_q     <= '0;
            cont_nx_q <= cont_mode_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_SLOW: begin
          if (cnt_q == (cont_nx_q ? CW'(2) : CW'(1))) phase_q <= PH_SREC;
          else cnt_q <= cnt_q + 1'b1;
        end
        PH_SREC: phase_q <= PH_STA;
        PH_STA: begin
          phase_q <= cont_nx_q ? PH_GAP : PH_IDLE;
          cnt_q   <= '0;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serial_irq_host_chk.sv
module serial_irq_host_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        line_i,
  input logic        line_o,
  input logic        line_oe,
  input logic        status_vld_o,
  input logic [16:0] irq_status_o,
  input logic        idle_wait
);

  logic       drv_lo;
  logic [2:0] run_q;

  assign drv_lo = line_oe && !line_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (drv_lo) run_q <= (run_q == 3'd7) ? run_q : run_q + 1'b1;
    else run_q <= '0;
  end

  p_one_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && line_o) |=> !line_oe);

  p_vld_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status_vld_o |=> !status_vld_o);

  p_status_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !status_vld_o |-> $stable(irq_status_o));

  p_lowrun_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drv_lo |-> run_q <= 3'd2);

  p_lowrun_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_lo && run_q != 3'd0) |-> run_q >= 3'd2);

  p_takeover_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_wait && !line_i) |=> (line_oe && !line_o));

endmodule

bind serial_irq_host serial_irq_host_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .line_i       (line_i),
  .line_o       (line_o),
  .line_oe      (line_oe),
  .status_vld_o (status_vld_o),
  .irq_status_o (irq_status_o),
  .idle_wait    (phase_q == PH_IDLE)
);

// File: tb/serial_irq_host_tb_top.sv
module serial_irq_host_tb_top;
  localparam int GAP   = 4;
  localparam int SIDLE = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cont_mode = 1'b1;
  logic        poll = 1'b0;
  logic        slv_low = 1'b0;
  logic        slv_high = 1'b0;
  logic        line;
  logic        host_o, host_oe, vld;
  logic [16:0] status;
  int          tests = 0;
  int          fails = 0;
  int          cyc = 0;
  bit          quiet_b = 1'b0;

  assign line = (host_oe ? host_o : 1'b1) & ~slv_low;

  serial_irq_host #(.IDLE_GAP(GAP), .STOP_IDLE(SIDLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(line), .line_o(host_o), .line_oe(host_oe),
    .cont_mode_i(cont_mode), .poll_i(poll), .irq_status_o(status), .status_vld_o(vld)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog (R1..all): got %0d cycles expected under 100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int exp_stop_len(input bit nxt);
    return nxt ? 3 : 2;
  endfunction

  function automatic int exp_vector(input logic [16:0] pat);
    return int'(pat);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_cycle(input logic [16:0] pat, input bit nxt, input int kick,
                           input int exp_wait, input bit noise);
    int n, lows, idle, bad_oe, bad_vld, hold;
    cont_mode = nxt;
    if (kick == 0) begin
      n = 0;
      do begin
        @(negedge clk);
        n++;
        poll    = noise && n == 1;
        slv_low = noise && n == 1;
      end while (!(host_oe && !host_o) && n < 1000);
      poll = 1'b0; slv_low = 1'b0;
      if (exp_wait >= 0) chk(n == exp_wait, "R7", "gap to first start low", n, exp_wait);
    end else begin
      hold = 2 + int'($urandom % 6);
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk(!host_oe, "R8", "quiet rest released", int'(host_oe), 0);
      end
      poll    = kick[0];
      slv_low = kick[1];
      @(negedge clk);
      poll = 1'b0; slv_low = 1'b0;
      if (kick >= 2) begin
        chk(host_oe && !host_o, (kick == 3) ? "R10" : "R9", "host low right after request",
            int'({host_oe, host_o}), 2);
      end else begin
        chk(!host_oe, "R8", "poll start state 0 released", int'(host_oe), 0);
        @(negedge clk);
        chk(host_oe && !host_o, "R8", "host low after poll", int'({host_oe, host_o}), 2);
      end
    end
    lows = 0;
    while (host_oe && !host_o && lows < 10) begin lows++; @(negedge clk); end
    chk(lows == 3, "R2", "start low states", lows, 3);
    chk(host_oe && host_o, "R6", "start recover high", int'({host_oe, host_o}), 3);
    @(negedge clk);
    chk(!host_oe, "R6", "start turnaround released", int'(host_oe), 0);
    bad_oe = 0; bad_vld = 0;
    for (int d = 0; d < 51; d++) begin
      @(negedge clk);
      slv_low  = (d % 3 == 0) && pat[d / 3];
      slv_high = (d % 3 == 1) && pat[d / 3];
      if (host_oe) bad_oe++;
      if (vld) bad_vld++;
    end
    @(negedge clk);
    slv_low = 1'b0; slv_high = 1'b0;
    chk(bad_oe == 0, "R3", "host drive in data frames", bad_oe, 0);
    chk(bad_vld == 0, "R4", "strobe during data", bad_vld, 0);
    chk(vld, "R4", "strobe after last frame", int'(vld), 1);
    chk(int'(status) == exp_vector(pat), "R3", "status vector", int'(status), exp_vector(pat));
    idle = 0;
    while (!host_oe && idle < 20) begin idle++; @(negedge clk); end
    chk(idle == SIDLE, "R5", "stop idle states", idle, SIDLE);
    lows = 0;
    while (host_oe && !host_o && lows < 10) begin lows++; @(negedge clk); end
    chk(lows == exp_stop_len(nxt), "R5", "stop pulse width", lows, exp_stop_len(nxt));
    chk(host_oe && host_o, "R6", "stop recover high", int'({host_oe, host_o}), 3);
    @(negedge clk);
    chk(!host_oe, "R6", "stop turnaround released", int'(host_oe), 0);
    chk(!vld && int'(status) == exp_vector(pat), "R4", "status held after strobe",
        int'(status), exp_vector(pat));
    quiet_b = !nxt;
  endtask

  initial begin
    logic [16:0] pat;
    bit          nxt;
    int          kick;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!host_oe && !vld && status == '0, "R1", "reset outputs",
        int'({host_oe, vld, status}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!host_oe, "R1", "first state after reset released", int'(host_oe), 0);
    run_cycle(17'h1FFFF, 1'b1, 0, GAP, 1'b0);
    run_cycle(17'h00000, 1'b0, 0, GAP + 2, 1'b1);
    run_cycle(17'h00004, 1'b0, 1, -1, 1'b0);
    run_cycle(17'h10001, 1'b0, 2, -1, 1'b0);
    run_cycle(17'h0AAAA, 1'b1, 3, -1, 1'b0);
    run_cycle(17'h15555, 1'b1, 0, GAP + 2, 1'b1);
    for (int r = 0; r < 16; r++) begin
      pat  = 17'($urandom);
      nxt  = 1'($urandom);
      kick = quiet_b ? 1 + int'($urandom % 3) : 0;
      run_cycle(pat, nxt, kick, quiet_b ? -1 : GAP + 2, 1'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule